// File: doc/BRIEF.md
# SPI ADC Acquisition Sequencer

This block runs an external 24-bit delta-sigma converter over a four-wire SPI link from one system clock. After reset it keeps the link quiet for a programmable settling interval. It then writes a short fixed list of converter configuration registers. After that it repeats an acquisition loop for as long as it runs. In each pass it waits for the converter's active-low ready line, sends the read-data command byte, and pauses with the serial clock parked. It then clocks in a 24-bit result and presents it as a parallel word with a one-cycle valid strobe.

The serial clock comes from an internal divider of `SCLK_DIV` system cycles per period, for example 5 for a 20 MHz system clock and a 4 MHz serial clock. The link runs in SPI mode 1, MSB first. A 2-bit channel selector goes out on two pins that drive the converter's digital inputs. The value is captured at the start of each read and held until the next one.

Top module: `spi_adc_seq`

## Requirements
- R1: While reset is asserted and just after it, `cs_n` is 1 and `sclk`, `mosi`, `data_valid`, `data` and `chan_pins` are all 0.
- R2: `cs_n` stays high for at least `PWRUP_CYC` - 1 system cycles after reset is released, whatever `drdy_n` does.
- R3: After the power-up wait, the block sends `INIT_LEN` (default 4) configuration frames, each on its own chip-select window, before any read. Each frame is 24 bits, MSB first: {8'h50 OR register address, 8'h00, value}. The addresses 0, 1, 2 and 3 carry the values 8'h04, 8'h08, 8'h00 and 8'hF0, in that order.
- R4: The link uses SPI mode 1. `sclk` is low whenever `cs_n` is high. While `cs_n` is low, `mosi` changes only in a cycle where `sclk` rises. `miso` is sampled as `sclk` falls.
- R5: A read starts only after `drdy_n` is seen low. In its single chip-select window it carries exactly 32 clocks. The first 8 carry the command 8'h01, and the 24 data clocks send `mosi` = 0. Between the 8th and 9th clock `sclk` stays low for at least `GAP_SCLK` x `SCLK_DIV` system cycles.
- R6: `data` takes the 24 bits shifted in during the data clocks, the first bit as bit 23. `data_valid` is high for exactly one system cycle when `data` updates, and `data` holds its value at all other times.
- R7: Between any two chip-select windows, `cs_n` stays high for at least `SCLK_DIV` system cycles.
- R8: `chan_pins` takes the value of `chan_sel` when a read window opens. It holds that value while the window is open, even if `chan_sel` changes.
- R9: Once initialisation is done, no chip-select window opens while `drdy_n` stays high, and `data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_n | input | 1 | Converter data-ready, active low (asynchronous) |
| chan_sel | input | 2 | Channel code to drive to the converter's digital pins |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| chan_pins | output | 2 | Channel code driven to the converter |
| data | output | 24 | Last conversion result |
| data_valid | output | 1 | One-cycle strobe marking an update of `data` |

## Verification
The bench drives results of all ones, a lone LSB, a lone MSB and a mixed pattern. These expose a shifter that drops or duplicates the edge bit, or that samples on the wrong clock edge and so returns the word shifted by one position. It measures the parked gap after the command byte and the high time between windows. A sequencer that skips the pause or chains frames under one chip select fails those measurements. It changes `chan_sel` during an open read, which catches channel pins that follow the input live. It also holds `drdy_n` high after initialisation, which catches a loop that polls without waiting for the ready line.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_INIT_XFER,
        ST_GAP,
        ST_WAIT_RDY,
        ST_CMD_XFER,
        ST_PAUSE,
        ST_DATA_XFER
    } seq_state_e;

    localparam logic [7:0] CMD_WREG  = 8'h50;
    localparam logic [7:0] CMD_RDATA = 8'h01;
    localparam int         ROM_SLOTS = 4;

    // {register address, register value}
    function automatic logic [15:0] init_entry(input int idx);
        case (idx)
            0:       return {8'h00, 8'h04};
            1:       return {8'h01, 8'h08};
            2:       return {8'h02, 8'h00};
            3:       return {8'h03, 8'hF0};
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/spi_adc_sync.sv
module spi_adc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    // reset to 1: the ready line is active low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_adc_init_rom.sv
module spi_adc_init_rom
    import spi_adc_pkg::*;
#(
    parameter int INIT_LEN = 4,
    parameter int DATA_W   = 24,
    localparam int IW      = (INIT_LEN < 1) ? 1 : $clog2(INIT_LEN + 1)
) (
    input  logic [IW-1:0]     idx,
    output logic [DATA_W-1:0] word
);
    logic [15:0] entry;

    always_comb begin
        entry = init_entry(int'(idx));
        // write-register frame: command|address, count-1 = 0, value
        word  = {CMD_WREG | entry[15:8], 8'h00, entry[7:0], {(DATA_W-24){1'b0}}};
    end
endmodule

// File: rtl/spi_adc_shifter.sv
module spi_adc_shifter #(
    parameter int SCLK_DIV = 5,
    parameter int DATA_W   = 24,
    localparam int HI_CYC  = SCLK_DIV / 2,
    localparam int CW      = $clog2(SCLK_DIV),
    localparam int BW      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BW-1:0]     nbits,
    input  logic [DATA_W-1:0] tx,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx
);
    typedef struct packed {
        logic              active;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     left;
        logic              sclk;
        logic              mosi;
        logic [DATA_W-1:0] txsh;
        logic [DATA_W-1:0] rxsh;
        logic              done;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                // first rising edge: present MSB
                s_d.active = 1'b1;
                s_d.cnt    = '0;
                s_d.left   = nbits;
                s_d.sclk   = 1'b1;
                s_d.mosi   = tx[DATA_W-1];
                s_d.txsh   = tx << 1;
                s_d.rxsh   = '0;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CW'(HI_CYC - 1)) begin
                // falling edge: capture the converter's bit
                s_d.sclk = 1'b0;
                s_d.rxsh = {s_q.rxsh[DATA_W-2:0], miso};
            end
            if (s_q.cnt == CW'(SCLK_DIV - 1)) begin
                s_d.cnt = '0;
                if (s_q.left == BW'(1)) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.left = s_q.left - 1'b1;
                    s_d.sclk = 1'b1;
                    s_d.mosi = s_q.txsh[DATA_W-1];
                    s_d.txsh = s_q.txsh << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk = s_q.sclk;
    assign mosi = s_q.mosi;
    assign done = s_q.done;
    assign rx   = s_q.rxsh;
endmodule

// File: rtl/spi_adc_seq.sv
module spi_adc_seq
    import spi_adc_pkg::*;
#(
    parameter int PWRUP_CYC = 200000,
    parameter int SCLK_DIV  = 5,
    parameter int GAP_SCLK  = 7,
    parameter int INIT_LEN  = 4,
    parameter int DATA_W    = 24,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_n,
    input  logic [1:0]        chan_sel,
    input  logic              miso,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic [1:0]        chan_pins,
    output logic [DATA_W-1:0] data,
    output logic              data_valid
);
    localparam int PAUSE_CYC = GAP_SCLK * SCLK_DIV;
    localparam int CSGAP_CYC = SCLK_DIV;
    localparam int TMAX_A    = (PWRUP_CYC > PAUSE_CYC) ? PWRUP_CYC : PAUSE_CYC;
    localparam int TMAX      = (TMAX_A > CSGAP_CYC) ? TMAX_A : CSGAP_CYC;
    localparam int TW        = $clog2(TMAX + 1);
    localparam int IW        = (INIT_LEN < 1) ? 1 : $clog2(INIT_LEN + 1);
    localparam int BW        = $clog2(DATA_W + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [TW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic              init_done;
        logic              cs_n;
        logic              start;
        logic [1:0]        chan;
        logic [DATA_W-1:0] data;
        logic              valid;
    } seq_t;

    seq_t q_d, q_q;

    logic              rdy_n_s;
    logic              sh_done;
    logic [DATA_W-1:0] sh_rx;
    logic [DATA_W-1:0] rom_word;
    logic [DATA_W-1:0] tx_word;
    logic [BW-1:0]     tx_bits;

    spi_adc_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (drdy_n),
        .dout  (rdy_n_s)
    );

    spi_adc_init_rom #(.INIT_LEN(INIT_LEN), .DATA_W(DATA_W)) u_rom (
        .idx  (q_q.idx),
        .word (rom_word)
    );

    always_comb begin
        case (q_q.st)
            ST_CMD_XFER:  tx_word = {CMD_RDATA, {(DATA_W-8){1'b0}}};
            ST_DATA_XFER: tx_word = '0;
            default:      tx_word = rom_word;
        endcase
        tx_bits = (q_q.st == ST_CMD_XFER) ? BW'(8) : BW'(DATA_W);
    end

    spi_adc_shifter #(.SCLK_DIV(SCLK_DIV), .DATA_W(DATA_W)) u_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .start (q_q.start),
        .nbits (tx_bits),
        .tx    (tx_word),
        .miso  (miso),
        .sclk  (sclk),
        .mosi  (mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    always_comb begin
        q_d       = q_q;
        q_d.start = 1'b0;
        q_d.valid = 1'b0;
        case (q_q.st)
            ST_PWRUP: begin
                q_d.cnt = q_q.cnt + 1'b1;
                if (q_q.cnt == TW'(PWRUP_CYC - 1)) begin
                    q_d.cnt = '0;
                    if (INIT_LEN == 0) begin
                        q_d.init_done = 1'b1;
                        q_d.st        = ST_WAIT_RDY;
                    end else begin
                        q_d.st    = ST_INIT_XFER;
                        q_d.cs_n  = 1'b0;
                        q_d.start = 1'b1;
                    end
                end
            end
            ST_INIT_XFER: begin
                if (sh_done) begin
                    q_d.cs_n = 1'b1;
                    q_d.idx  = q_q.idx + 1'b1;
                    q_d.cnt  = '0;
                    q_d.st   = ST_GAP;
                end
            end
            ST_GAP: begin
                q_d.cnt = q_q.cnt + 1'b1;
                if (q_q.cnt == TW'(CSGAP_CYC - 1)) begin
                    q_d.cnt = '0;
                    if (q_q.init_done || q_q.idx == IW'(INIT_LEN)) begin
                        q_d.init_done = 1'b1;
                        q_d.st        = ST_WAIT_RDY;
                    end else begin
                        q_d.st    = ST_INIT_XFER;
                        q_d.cs_n  = 1'b0;
                        q_d.start = 1'b1;
                    end
                end
            end
            ST_WAIT_RDY: begin
                if (!rdy_n_s) begin
                    q_d.st    = ST_CMD_XFER;
                    q_d.cs_n  = 1'b0;
                    q_d.start = 1'b1;
                    q_d.chan  = chan_sel;
                end
            end
            ST_CMD_XFER: begin
                if (sh_done) begin
                    q_d.cnt = '0;
                    q_d.st  = ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                q_d.cnt = q_q.cnt + 1'b1;
                if (q_q.cnt == TW'(PAUSE_CYC - 1)) begin
                    q_d.cnt   = '0;
                    q_d.st    = ST_DATA_XFER;
                    q_d.start = 1'b1;
                end
            end
            ST_DATA_XFER: begin
                if (sh_done) begin
                    q_d.data  = sh_rx;
                    q_d.valid = 1'b1;
                    q_d.cs_n  = 1'b1;
                    q_d.cnt   = '0;
                    q_d.st    = ST_GAP;
                end
            end
            default: q_d.st = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q      <= '0;
            q_q.st   <= ST_PWRUP;
            q_q.cs_n <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign cs_n       = q_q.cs_n;
    assign chan_pins  = q_q.chan;
    assign data       = q_q.data;
    assign data_valid = q_q.valid;
endmodule

// File: rtl/spi_adc_seq_chk.sv
module spi_adc_seq_chk #(
    parameter int PWRUP_CYC = 200000,
    parameter int SCLK_DIV  = 5,
    parameter int DATA_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sclk,
    input logic [1:0]        chan_pins,
    input logic [DATA_W-1:0] data,
    input logic              data_valid
);
    localparam int AW = $clog2(PWRUP_CYC + 1);
    localparam int HW = $clog2(SCLK_DIV + 1);

    logic [AW-1:0] age_q;
    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
            hi_q  <= '0;
        end else begin
            if (age_q != AW'(PWRUP_CYC)) age_q <= age_q + 1'b1;
            if (!cs_n)                     hi_q <= '0;
            else if (hi_q != HW'(SCLK_DIV)) hi_q <= hi_q + 1'b1;
        end
    end

    p_quiet_powerup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < AW'(PWRUP_CYC)) |-> cs_n);

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> $stable(data));

    p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_q >= HW'(SCLK_DIV)));

    p_chan_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(chan_pins));
endmodule

bind spi_adc_seq spi_adc_seq_chk #(
    .PWRUP_CYC (PWRUP_CYC),
    .SCLK_DIV  (SCLK_DIV),
    .DATA_W    (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .chan_pins  (chan_pins),
    .data       (data),
    .data_valid (data_valid)
);

// File: tb/spi_adc_seq_tb.sv
module spi_adc_seq_tb;
    localparam int PWRUP    = 40;
    localparam int DIV      = 5;
    localparam int GAPS     = 3;
    localparam int NINIT    = 4;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drdy_n = 1'b1;
    logic [1:0]  chan_sel = 2'b00;
    logic        miso = 1'b0;
    logic        cs_n, sclk, mosi, data_valid;
    logic [1:0]  chan_pins;
    logic [23:0] data;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    spi_adc_seq #(
        .PWRUP_CYC (PWRUP),
        .SCLK_DIV  (DIV),
        .GAP_SCLK  (GAPS),
        .INIT_LEN  (NINIT)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .drdy_n     (drdy_n),
        .chan_sel   (chan_sel),
        .miso       (miso),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .mosi       (mosi),
        .chan_pins  (chan_pins),
        .data       (data),
        .data_valid (data_valid)
    );

    // converter model and link monitor, sampled on the falling clock edge
    logic [23:0] slave_word = 24'h0;
    logic [63:0] fr_val [0:31];
    int          fr_bits [0:31];
    int          fr_pause [0:31];
    int          nframes = 0;
    int          cur_bits = 0;
    int          cur_pause = 0;
    logic [63:0] cur_val = 0;
    int          hi_run = 0;
    int          min_gap = 1 << 30;
    int          first_low = -1;
    int          cyc = 0;
    int          viol = 0;
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0;
        end else begin
            cyc = cyc + 1;
            if (cs_n && sclk) viol = viol + 1;
            if (!cs_n && p_cs) begin
                if (hi_run < min_gap) min_gap = hi_run;
                if (first_low < 0) first_low = cyc;
                cur_bits = 0; cur_pause = 0; cur_val = 0;
            end
            if (!cs_n) begin
                if (!p_cs == 1'b1 && mosi != p_mosi && !(sclk && !p_sclk)) viol = viol + 1;
                if (sclk && !p_sclk)
                    miso = (cur_bits >= 8 && cur_bits < 32) ? slave_word[31-cur_bits] : 1'b0;
                if (!sclk && p_sclk) begin
                    cur_val  = {cur_val[62:0], mosi};
                    cur_bits = cur_bits + 1;
                end
                if (!sclk && cur_bits == 8) cur_pause = cur_pause + 1;
                hi_run = 0;
            end else begin
                hi_run = hi_run + 1;
            end
            if (cs_n && !p_cs && nframes < 32) begin
                fr_val[nframes]   = cur_val;
                fr_bits[nframes]  = cur_bits;
                fr_pause[nframes] = cur_pause;
                nframes = nframes + 1;
            end
            p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog actual=0x%0h expected=0x0", WATCHDOG);
        finish_run();
    end

    task automatic wait_frames(input int n);
        for (int i = 0; i < 20000 && nframes < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 link idle", {cs_n, sclk, mosi}, 3'b100);
        check(data == 24'h0 && data_valid == 1'b0 && chan_pins == 2'b00, "R1 outputs clear",
              {data, data_valid, chan_pins}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && data_valid == 1'b0, "R1 after release", {cs_n, data_valid}, 2'b10);
    endtask

    task automatic t_init();
        logic [23:0] exp;
        logic [7:0]  vals [0:3];
        vals[0] = 8'h04; vals[1] = 8'h08; vals[2] = 8'h00; vals[3] = 8'hF0;
        wait_frames(NINIT);
        check(first_low >= PWRUP - 1, "R2 power-up quiet", first_low, PWRUP - 1);
        check(nframes == NINIT, "R3 frame count", nframes, NINIT);
        for (int i = 0; i < NINIT; i++) begin
            exp = {8'h50 | 8'(i), 8'h00, vals[i]};
            check(fr_bits[i] == 24, "R3 frame length", fr_bits[i], 24);
            check(fr_val[i][23:0] == exp, "R3 frame content", fr_val[i][23:0], exp);
        end
        repeat (30) @(negedge clk);
        check(nframes == NINIT && data_valid == 1'b0, "R9 no read without ready", nframes, NINIT);
    endtask

    task automatic t_read(input logic [23:0] word, input logic [1:0] ch);
        int n0;
        int seen;
        n0 = nframes;
        slave_word = word;
        chan_sel   = ch;
        drdy_n     = 1'b0;
        for (int i = 0; i < 2000 && cs_n; i++) @(negedge clk);
        drdy_n   = 1'b1;
        chan_sel = ~ch;
        seen = 0;
        for (int i = 0; i < 4000 && !data_valid; i++) @(negedge clk);
        seen = data_valid;
        check(seen == 1 && data == word, "R6 result word", data, word);
        check(chan_pins == ch, "R8 channel held", chan_pins, ch);
        @(negedge clk);
        check(data_valid == 1'b0, "R6 strobe width", data_valid, 0);
        wait_frames(n0 + 1);
        check(nframes == n0 + 1 && fr_bits[n0] == 32, "R5 read clocks", fr_bits[n0], 32);
        check(fr_val[n0][31:0] == {8'h01, 24'h0}, "R5 command and idle mosi", fr_val[n0][31:0], 32'h01000000);
        check(fr_pause[n0] >= GAPS * DIV, "R5 pause length", fr_pause[n0], GAPS * DIV);
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic t_idle();
        int n0;
        logic [23:0] d0;
        n0 = nframes;
        d0 = data;
        drdy_n = 1'b1;
        repeat (300) @(negedge clk);
        check(nframes == n0, "R9 idle frames", nframes, n0);
        check(data == d0, "R9 idle data", data, d0);
    endtask

    initial begin
        t_reset();
        t_init();
        t_read(24'hA5C3F0, 2'b01);
        t_read(24'h000001, 2'b10);
        t_read(24'hFFFFFF, 2'b11);
        t_read(24'h800000, 2'b00);
        t_idle();
        check(viol == 0, "R4 mode 1 edges", viol, 0);
        check(min_gap >= DIV, "R7 chip-select gap", min_gap, DIV);
        finish_run();
    end
endmodule